// File: doc/BRIEF.md
# Big-Endian Byte Lane Load/Store Unit

This block sits between a processor datapath and a data memory that is one 32-bit word wide and has a write enable per byte. The datapath hands it one request per cycle: a byte address that has already been formed upstream, a flag saying whether the access is a single byte or a whole word, a load/store select and the store source register. From these the unit forms the word address, the read enable, four per-byte write enables and a store word with the bytes placed in the right lanes.

Byte lanes are numbered big-endian. Byte offset 0 within a word is its most significant byte. A byte store copies the low byte of the source register into every lane. Only the one write enable that matches the offset is raised, so the other three bytes of the memory word keep their contents.

Loads are split across two cycles. The memory returns its word in the cycle after the request, so the unit registers the byte offset and the access size. In that next cycle it picks the result out of the returned word, either the whole word or one byte zero-extended to 32 bits. A word access whose address is not a multiple of four is flagged as misaligned and leaves memory untouched.

Top module: `be_lane_unit`

## Requirements
- R1: `mem_word_addr` equals `req_addr` shifted right by two, whatever the access type.
- R2: An aligned-or-byte store raises exactly one bit of `mem_we` for a byte access, bit i for byte offset i = `req_addr[1:0]` (offset 0 → 4'b0001, offset 3 → 4'b1000).
- R3: For a byte store, `mem_wdata` carries `store_src[7:0]` in all four byte lanes.
- R4: An aligned word store drives `mem_we` = 4'b1111 and `mem_wdata` = `store_src`.
- R5: A word access with `req_addr[1:0]` ≠ 2'b00 raises `misaligned`, drives `mem_we` to 0 and `mem_re` to 0, and produces no `load_valid` in the following cycle.
- R6: A byte load raises `mem_re`. In the next cycle `load_valid` is 1 and `load_result` holds, in bits 7:0, the byte at its offset in `mem_rdata`: offset 0 is bits 31:24, offset 1 is 23:16, offset 2 is 15:8 and offset 3 is 7:0. Bits 31:8 are zero.
- R7: An aligned word load raises `mem_re`. In the next cycle `load_valid` is 1 and `load_result` equals `mem_rdata`.
- R8: With `req_valid` low, `mem_we`, `mem_re` and `misaligned` are all 0.
- R9: Whenever `load_valid` is 0, and during and right after reset, `load_result` is 0. An asynchronous reset clears a pending load at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 32 | Byte address of the access |
| store_src | input | 32 | Store source register |
| mem_rdata | input | 32 | Word returned by memory, one cycle after `mem_re` |
| mem_word_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 4 | Per-byte write enables, bit i = byte offset i |
| mem_wdata | output | 32 | Lane-aligned store word |
| misaligned | output | 1 | Misaligned word access flag |
| load_valid | output | 1 | Load result is valid this cycle |
| load_result | output | 32 | Extracted, zero-extended load result |

## Verification
The assertions assume that the request inputs are stable around the clock edge. They also assume that `mem_rdata` in the cycle after a load really is the word read at that address. `req_store` and `req_word` are only taken as meaningful while `req_valid` is high. The bench changes every input at the falling edge, and it presents the memory word only in the cycle after the load request, with the request itself dropped by then. Every vector is separated from the next by an idle cycle, so no two loads overlap.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/be_lsu_rst_sync.sv
module be_lsu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/be_lsu_addr_dec.sv
module be_lsu_addr_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                           req_valid,
  input  logic                           req_word,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic [ADDR_W-$clog2(LANES)-1:0] word_addr,
  output logic [$clog2(LANES)-1:0]       lane_ofs,
  output logic [LANES-1:0]               lane_sel,
  output logic                           misaligned,
  output logic                           acc_ok
);
  localparam int unsigned OFS_W = $clog2(LANES);

  assign word_addr = req_addr[ADDR_W-1:OFS_W];
  assign lane_ofs  = req_addr[OFS_W-1:0];

  // one-hot lane select, bit i for byte offset i (big-endian lane i)
  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign lane_sel[i] = (lane_ofs == OFS_W'(i));
  end

  assign misaligned = req_valid && req_word && (lane_ofs != '0);
  assign acc_ok     = req_valid && !misaligned;
endmodule

// File: rtl/be_lsu_store_align.sv
module be_lsu_store_align #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                    do_store,
  input  logic                    is_word,
  input  logic [DATA_W/8-1:0]     lane_sel,
  input  logic [DATA_W-1:0]       store_src,
  output logic [DATA_W/8-1:0]     we,
  output logic [DATA_W-1:0]       wdata
);
  import be_lsu_pkg::*;
  localparam int unsigned LANES = DATA_W / BYTE_W;

  logic [BYTE_W-1:0] low_byte;
  assign low_byte = store_src[BYTE_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned HI = DATA_W - 1 - BYTE_W * i;
    assign wdata[HI -: BYTE_W] = is_word ? store_src[HI -: BYTE_W] : low_byte;
    assign we[i] = do_store && (is_word || lane_sel[i]);
  end
endmodule

// File: rtl/be_lsu_load_extract.sv
module be_lsu_load_extract #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic                          is_word,
  input  logic [$clog2(DATA_W/8)-1:0]   lane_ofs,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          load_valid,
  output logic [DATA_W-1:0]             load_result
);
  import be_lsu_pkg::*;
  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned OFS_W = $clog2(LANES);

  logic             ld_valid_q, ld_valid_d;
  acc_size_e        ld_size_q, ld_size_d;
  logic [OFS_W-1:0] ld_ofs_q, ld_ofs_d;

  always_comb begin
    ld_valid_d = capture;
    ld_size_d  = ld_size_q;
    ld_ofs_d   = ld_ofs_q;
    if (capture) begin
      ld_size_d = is_word ? SZ_WORD : SZ_BYTE;
      ld_ofs_d  = lane_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_q <= 1'b0;
      ld_size_q  <= SZ_BYTE;
      ld_ofs_q   <= '0;
    end else begin
      ld_valid_q <= ld_valid_d;
      ld_size_q  <= ld_size_d;
      ld_ofs_q   <= ld_ofs_d;
    end
  end

  logic [BYTE_W-1:0] lane_byte [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_byte[i] = mem_rdata[DATA_W-1-BYTE_W*i -: BYTE_W];
  end

  logic [BYTE_W-1:0] picked;
  always_comb begin
    picked = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ld_ofs_q == OFS_W'(i)) picked = lane_byte[i];
    end
  end

  always_comb begin
    if (!ld_valid_q)              load_result = '0;
    else if (ld_size_q == SZ_WORD) load_result = mem_rdata;
    else                           load_result = {{(DATA_W-BYTE_W){1'b0}}, picked};
  end

  assign load_valid = ld_valid_q;
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic                                req_store,
  input  logic                                req_word,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                   store_src,
  input  logic [DATA_W-1:0]                   mem_rdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_word_addr,
  output logic                                mem_re,
  output logic [DATA_W/8-1:0]                 mem_we,
  output logic [DATA_W-1:0]                   mem_wdata,
  output logic                                misaligned,
  output logic                                load_valid,
  output logic [DATA_W-1:0]                   load_result
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(LANES);

  logic             rst_q_n;
  logic [OFS_W-1:0] lane_ofs;
  logic [LANES-1:0] lane_sel;
  logic             acc_ok;
  logic             do_store;
  logic             do_load;

  be_lsu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  be_lsu_addr_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .req_valid  (req_valid),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .word_addr  (mem_word_addr),
    .lane_ofs   (lane_ofs),
    .lane_sel   (lane_sel),
    .misaligned (misaligned),
    .acc_ok     (acc_ok)
  );

  assign do_store = acc_ok && req_store;
  assign do_load  = acc_ok && !req_store;
  assign mem_re   = do_load;

  be_lsu_store_align #(.DATA_W(DATA_W)) u_st (
    .do_store  (do_store),
    .is_word   (req_word),
    .lane_sel  (lane_sel),
    .store_src (store_src),
    .we        (mem_we),
    .wdata     (mem_wdata)
  );

  be_lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .capture     (do_load),
    .is_word     (req_word),
    .lane_ofs    (lane_ofs),
    .mem_rdata   (mem_rdata),
    .load_valid  (load_valid),
    .load_result (load_result)
  );
endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                req_valid,
  input logic                                req_store,
  input logic                                req_word,
  input logic [ADDR_W-1:0]                   req_addr,
  input logic [DATA_W-1:0]                   store_src,
  input logic [DATA_W/8-1:0]                 mem_we,
  input logic [DATA_W-1:0]                   mem_wdata,
  input logic                                mem_re,
  input logic                                misaligned,
  input logic                                load_valid,
  input logic [DATA_W-1:0]                   load_result
);
  logic byte_st, word_st_al;
  assign byte_st    = req_valid && req_store && !req_word;
  assign word_st_al = req_valid && req_store && req_word && (req_addr[1:0] == 2'b00);

  // R2
  byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_st |-> ($countones(mem_we) == 1));

  // R3
  byte_store_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_st |-> (mem_wdata == {(DATA_W/8){store_src[7:0]}}));

  // R4
  word_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_st_al |-> (&mem_we && mem_wdata == store_src));

  // R5
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (mem_we == '0 && !mem_re));

  // R5
  misalign_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misaligned && !req_store) |=> !load_valid);

  // R6
  byte_load_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !req_word) |=> (load_valid && load_result[DATA_W-1:8] == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_we == '0 && !mem_re && !misaligned));

  // R9
  idle_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (load_result == '0));
endmodule

bind be_lane_unit be_lane_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_word    (req_word),
  .req_addr    (req_addr),
  .store_src   (store_src),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .mem_re      (mem_re),
  .misaligned  (misaligned),
  .load_valid  (load_valid),
  .load_result (load_result)
);

// File: tb/sim_be_lane_unit.sv
module sim_be_lane_unit;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_word;
  logic [31:0] req_addr, store_src, mem_rdata;
  logic [29:0] mem_word_addr;
  logic        mem_re, misaligned, load_valid;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata, load_result;

  int checks = 0;
  int errors = 0;

  be_lane_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_word(req_word), .req_addr(req_addr), .store_src(store_src),
    .mem_rdata(mem_rdata), .mem_word_addr(mem_word_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .misaligned(misaligned),
    .load_valid(load_valid), .load_result(load_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        st;
    logic        wd;
    logic [31:0] addr;
    logic [31:0] src;
    logic [31:0] rdata;
    logic [3:0]  we;
    logic [31:0] wdata;
    logic        mis;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 14;
  // fields: store, word, addr, src, rdata, exp_we, exp_wdata, exp_mis, exp_load
  localparam logic [166:0] VEC [NV] = '{
    {1'b0,1'b0,32'h0000_0100,32'h0,         32'hA1B2_C3D4,4'h0,32'h0,         1'b0,32'h0000_00A1},
    {1'b0,1'b0,32'h0000_0103,32'h0,         32'hA1B2_C3D4,4'h0,32'h0,         1'b0,32'h0000_00D4},
    {1'b0,1'b0,32'h0000_1005,32'h0,         32'h1122_3344,4'h0,32'h0,         1'b0,32'h0000_0022},
    {1'b0,1'b0,32'hFFFF_FFFE,32'h0,         32'h8899_AABB,4'h0,32'h0,         1'b0,32'h0000_00AA},
    {1'b0,1'b1,32'h0000_0200,32'h0,         32'hDEAD_BEEF,4'h0,32'h0,         1'b0,32'hDEAD_BEEF},
    {1'b0,1'b1,32'h0000_0202,32'h0,         32'hDEAD_BEEF,4'h0,32'h0,         1'b1,32'h0},
    {1'b0,1'b1,32'h0000_0207,32'h0,         32'h5555_AAAA,4'h0,32'h0,         1'b1,32'h0},
    {1'b1,1'b0,32'h0000_0300,32'h1234_56FE,32'h0,         4'h1,32'hFEFE_FEFE,1'b0,32'h0},
    {1'b1,1'b0,32'h0000_0301,32'h0000_0011,32'h0,         4'h2,32'h1111_1111,1'b0,32'h0},
    {1'b1,1'b0,32'h0000_0302,32'hFFFF_FF80,32'h0,         4'h4,32'h8080_8080,1'b0,32'h0},
    {1'b1,1'b0,32'h0000_0303,32'hABCD_EF5A,32'h0,         4'h8,32'h5A5A_5A5A,1'b0,32'h0},
    {1'b1,1'b1,32'h0000_0400,32'hCAFE_F00D,32'h0,         4'hF,32'hCAFE_F00D,1'b0,32'h0},
    {1'b1,1'b1,32'h0000_0401,32'hCAFE_F00D,32'h0,         4'h0,32'h0,         1'b1,32'h0},
    {1'b1,1'b1,32'h0000_0403,32'h0102_0304,32'h0,         4'h0,32'h0,         1'b1,32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_store = 1'b0; req_word = 1'b0;
    req_addr = '0; store_src = '0; mem_rdata = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 load_valid in reset", {31'b0, load_valid}, 32'h0);
    chk("R9 load_result in reset", load_result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R8 idle
    chk("R8 idle we", {28'b0, mem_we}, 32'h0);
    chk("R8 idle re", {31'b0, mem_re}, 32'h0);
    chk("R8 idle misaligned", {31'b0, misaligned}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      @(negedge clk);
      req_valid = 1'b1; req_store = v.st; req_word = v.wd;
      req_addr = v.addr; store_src = v.src; mem_rdata = '0;
      #1;
      chk("R1 word address", {2'b0, mem_word_addr}, v.addr >> 2);
      chk("R5 misaligned flag", {31'b0, misaligned}, {31'b0, v.mis});
      chk(v.st ? "R2 R4 R5 write enables" : "R5 R8 load has no write enable",
          {28'b0, mem_we}, {28'b0, v.we});
      chk("R5 R6 R7 read enable", {31'b0, mem_re}, {31'b0, (!v.st && !v.mis)});
      if (v.st && !v.mis) chk(v.wd ? "R4 word store data" : "R3 byte store replicated",
                              mem_wdata, v.wdata);
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = v.rdata;
      #1;
      chk(v.mis ? "R5 no load after misaligned" : "R6 R7 load_valid",
          {31'b0, load_valid}, {31'b0, (!v.st && !v.mis)});
      chk(v.wd ? "R7 word load result" : "R6 byte load result", load_result, v.ld);
    end

    // R9 result returns to zero one cycle after a load completes
    @(negedge clk);
    mem_rdata = 32'hFFFF_FFFF;
    #1;
    chk("R9 load_valid drops", {31'b0, load_valid}, 32'h0);
    chk("R9 load_result zero when idle", load_result, 32'h0);

    // R9 asynchronous reset clears a pending load
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_word = 1'b1; req_addr = 32'h40;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mem_rdata = 32'h1234_5678;
    #0.5;
    chk("R7 word load pending before reset", load_result, 32'h1234_5678);
    rst_n = 1'b0;
    #0.5;
    chk("R9 reset clears load_valid", {31'b0, load_valid}, 32'h0);
    chk("R9 reset clears load_result", load_result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule